// File: doc/BRIEF.md
# Configurable-Width Cycle and Retire Counter Bank

This block holds the two free-running performance counters of a processor's control-register file: a clock-cycle counter that advances on every clock, and a retired-instruction counter that advances on each retire pulse from the pipeline. Each counter is read and written as two 32-bit words, a low word and a high word. Machine-level code sees a writable alias of each word. Less privileged code sees a read-only alias that a per-counter enable bit gates.

A single parameter, `CNT_WIDTH` (0 to 64, default 64), sets how many counter bits physically exist. Bits above that width always read zero, and writes to them are dropped. A width of 0 removes both counters completely. Two constant status outputs report a reduced width ("small counters") and a removed counter pair ("no counters"). Widths below 64 are allowed but are not standards-compliant.

The access decoder sorts every request into one of three classes: `ACC_NONE` (the address is not a counter word), `ACC_MACH` (a writable machine alias) and `ACC_USER` (a read-only user alias). The class, the privilege and the enable bits together decide whether the access is illegal. Read data and the illegal flag are combinational. A write takes effect at the next rising clock edge.

Top module: `ctr_csr_bank`

## Requirements
- R1: After reset every counter word reads zero.
- R2: The cycle counter increases by one on every clock edge. A carry out of bit 31 of the low word adds one to the high word, and the count wraps at the implemented width.
- R3: The retire counter increases by one at each clock edge where `retire_i` is high, with the same carry and wrap behaviour as the cycle counter.
- R4: A machine-privilege write loads the addressed word at the next edge. The other word of that counter keeps its value, and the counter does not increment in that cycle. The machine word addresses are 0xB00 (cycle low), 0xB80 (cycle high), 0xB02 (retire low) and 0xB82 (retire high). Privilege code 2'b11 is machine level, and every other code is less privileged.
- R5: For a width from 32 to 63, high-word bits at or above the width read zero and written values for them are discarded.
- R6: For a width from 1 to 31, the high words read zero. Writes to them are ignored and do not stall the counter. Low-word bits at or above the width read zero.
- R7: For a width of 0, all words read zero and every write is ignored.
- R8: `small_cnt` is 1 exactly when 0 < width < 64. `no_cnt` is 1 exactly when width is 0.
- R9: The user aliases are 0xC00 (cycle low), 0xC80 (cycle high), 0xC02 (retire low) and 0xC82 (retire high). A less privileged read of a user alias returns the counter word when `user_cnt_en` bit 0 (cycle) or bit 1 (retire) is set. Otherwise it raises `csr_illegal` and returns zero.
- R10: Any write to a user alias, at any privilege, raises `csr_illegal` and changes nothing.
- R11: A less privileged access to a machine alias raises `csr_illegal`, returns zero and changes nothing. A machine-privilege read of a user alias ignores the enable bits.
- R12: With no read or write strobe, `csr_illegal` is 0 and `csr_rdata` is zero. A read of an address outside the counter words returns zero and is not illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | One pulse per retired instruction |
| csr_addr | input | 12 | Register address of the access |
| csr_re | input | 1 | Read strobe |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| priv | input | 2 | Current privilege, 2'b11 = machine |
| user_cnt_en | input | 2 | Less-privileged read enables: bit 0 cycle, bit 1 retire |
| csr_rdata | output | 32 | Read data, zero unless a legal read hits a counter word |
| csr_illegal | output | 1 | Access must raise an illegal-instruction exception |
| small_cnt | output | 1 | Counters narrower than 64 bits |
| no_cnt | output | 1 | Counters removed (width 0) |

## Verification
The bench drives the same access stream into four instances of widths 64, 40, 20 and 0. This exposes any design that lets a masked bit survive a carry, or that keeps a written high-word bit above the width. The bench wraps the low word into the high word at its all-ones value and also wraps the whole counter. A design whose carry is cut or lands on the wrong bit shows a wrong high word here. A design that does not let a machine write win over a same-cycle retire pulse returns the write data plus one. With width 20, a write to the absent high word must leave the cycle count running: a design that stalls on that write reads one cycle short. The bench also checks each privilege and enable combination, so a design that lets user writes or disabled reads through shows a changed counter or a missing illegal flag.

// File: rtl/ctr_csr_pkg.sv
`timescale 1ns/1ps
package ctr_csr_pkg;

    // Number of counters handled by the bank (cycle, retire)
    localparam int NUM_CTR = 2;
    localparam int WORD_W  = 32;

    // Address fields: page in [11:8], high-word select in [7], index in [6:0]
    localparam logic [3:0] MACH_PAGE = 4'hB;
    localparam logic [3:0] USER_PAGE = 4'hC;
    localparam logic [6:0] CYC_IDX   = 7'd0;
    localparam logic [6:0] RET_IDX   = 7'd2;

    localparam logic [1:0] PRIV_MACH = 2'b11;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_MACH = 2'd1,
        ACC_USER = 2'd2
    } acc_kind_t;

endpackage

// File: rtl/ctr_pair.sv
`timescale 1ns/1ps
module ctr_pair #(
    parameter int CNT_WIDTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        inc,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    output logic [31:0] lo_word,
    output logic [31:0] hi_word
);

    localparam logic [63:0] MASK  = (CNT_WIDTH >= 64) ? {64{1'b1}}
                                  : ((64'd1 << CNT_WIDTH) - 64'd1);
    localparam bit          HI_EN = (CNT_WIDTH > 32);

    logic [63:0] cnt_q;
    logic [63:0] cnt_raw;
    logic        wr_hi_eff;

    // A write to a high word that does not exist is dropped entirely
    assign wr_hi_eff = wr_hi && HI_EN;

    always_comb begin
        cnt_raw = cnt_q;
        if (wr_lo) begin
            cnt_raw[31:0] = wdata;
        end else if (wr_hi_eff) begin
            cnt_raw[63:32] = wdata;
        end else if (inc) begin
            cnt_raw = cnt_q + 64'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_raw & MASK;
        end
    end

    assign lo_word = cnt_q[31:0];
    assign hi_word = cnt_q[63:32];

    // R5/R6: bits above the width never appear on the high word
    a_r5_hi_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_word & ~MASK[63:32]) == 32'd0);

    // R2/R3: plain increment, wrapping at the implemented width
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi_eff && inc) |=>
            ({hi_word, lo_word} == (($past({hi_word, lo_word}) + 64'd1) & MASK)));

    // R3: no increment, no write -> value holds
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi_eff && !inc) |=> $stable({hi_word, lo_word}));

    // R4: low-word write loads data and leaves the high word alone
    a_r4_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (lo_word == ($past(wdata) & MASK[31:0])) && $stable(hi_word));

endmodule

// File: rtl/ctr_access_dec.sv
`timescale 1ns/1ps
module ctr_access_dec
    import ctr_csr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [11:0]         addr,
    input  logic                re,
    input  logic                we,
    input  logic [1:0]          priv,
    input  logic [NUM_CTR-1:0]  user_en,
    output logic                ctr_sel,
    output logic                hi_sel,
    output logic                rd_ok,
    output logic                illegal,
    output logic [NUM_CTR-1:0]  wr_lo,
    output logic [NUM_CTR-1:0]  wr_hi
);

    acc_kind_t kind;
    logic      idx_ok;
    logic      is_mach;
    logic      wr_ok;

    assign idx_ok  = (addr[6:0] == CYC_IDX) || (addr[6:0] == RET_IDX);
    assign ctr_sel = addr[1];
    assign hi_sel  = addr[7];
    assign is_mach = (priv == PRIV_MACH);

    // Classify the access
    always_comb begin
        unique case (addr[11:8])
            MACH_PAGE: kind = idx_ok ? ACC_MACH : ACC_NONE;
            USER_PAGE: kind = idx_ok ? ACC_USER : ACC_NONE;
            default:   kind = ACC_NONE;
        endcase
    end

    // Legality per class
    always_comb begin
        case (kind)
            ACC_MACH: illegal = (re || we) && !is_mach;
            ACC_USER: illegal = we || (re && !is_mach && !user_en[ctr_sel]);
            default:  illegal = 1'b0;
        endcase
    end

    assign rd_ok = re && (kind != ACC_NONE) && !illegal;
    assign wr_ok = we && (kind == ACC_MACH) && !illegal;

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_strobe
        assign wr_lo[g] = wr_ok && !hi_sel && (ctr_sel == g[0]);
        assign wr_hi[g] = wr_ok &&  hi_sel && (ctr_sel == g[0]);
    end

    // R10: every write into the user page is illegal
    a_r10_user_wr_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr[11:8] == USER_PAGE && idx_ok) |-> illegal);

    // R11: an illegal access never produces a write strobe
    a_r11_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (wr_lo == '0 && wr_hi == '0));

    // R11: less privileged access to the machine page is always illegal
    a_r11_mach_page: assert property (@(posedge clk) disable iff (!rst_n)
        ((re || we) && !is_mach && addr[11:8] == MACH_PAGE && idx_ok) |-> illegal);

endmodule

// File: rtl/ctr_csr_bank.sv
`timescale 1ns/1ps
module ctr_csr_bank
    import ctr_csr_pkg::*;
#(
    parameter int CNT_WIDTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        retire_i,
    input  logic [11:0] csr_addr,
    input  logic        csr_re,
    input  logic        csr_we,
    input  logic [31:0] csr_wdata,
    input  logic [1:0]  priv,
    input  logic [1:0]  user_cnt_en,
    output logic [31:0] csr_rdata,
    output logic        csr_illegal,
    output logic        small_cnt,
    output logic        no_cnt
);

    localparam bit SMALL = (CNT_WIDTH > 0) && (CNT_WIDTH < 64);
    localparam bit NONE  = (CNT_WIDTH == 0);

    logic               ctr_sel;
    logic               hi_sel;
    logic               rd_ok;
    logic [NUM_CTR-1:0] wr_lo;
    logic [NUM_CTR-1:0] wr_hi;
    logic [NUM_CTR-1:0] inc;
    logic [31:0]        lo_w [NUM_CTR];
    logic [31:0]        hi_w [NUM_CTR];

    ctr_access_dec u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (csr_addr),
        .re      (csr_re),
        .we      (csr_we),
        .priv    (priv),
        .user_en (user_cnt_en),
        .ctr_sel (ctr_sel),
        .hi_sel  (hi_sel),
        .rd_ok   (rd_ok),
        .illegal (csr_illegal),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi)
    );

    // Counter 0 counts clocks, counter 1 counts retire pulses
    assign inc[0] = 1'b1;
    assign inc[1] = retire_i;

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        ctr_pair #(.CNT_WIDTH(CNT_WIDTH)) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (inc[g]),
            .wr_lo   (wr_lo[g]),
            .wr_hi   (wr_hi[g]),
            .wdata   (csr_wdata),
            .lo_word (lo_w[g]),
            .hi_word (hi_w[g])
        );
    end

    always_comb begin
        csr_rdata = '0;
        if (rd_ok) begin
            csr_rdata = hi_sel ? hi_w[ctr_sel] : lo_w[ctr_sel];
        end
    end

    assign small_cnt = SMALL;
    assign no_cnt    = NONE;

    // R12: quiet bus when no strobe is present
    a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_re || csr_we) |-> (!csr_illegal && csr_rdata == 32'd0));

    // R9: an illegal access never returns data
    a_r9_no_data_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> (csr_rdata == 32'd0));

endmodule

// File: tb/tb_ctr_csr_bank.sv
`timescale 1ns/1ps
module tb_ctr_csr_bank;

    localparam logic [1:0] PM = 2'b11;
    localparam logic [1:0] PU = 2'b00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire_i = 1'b0;
    logic [11:0] csr_addr = '0;
    logic        csr_re = 1'b0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [1:0]  priv = PM;
    logic [1:0]  user_cnt_en = 2'b00;

    logic [31:0] rd [4];
    logic        il [4];
    logic        sm [4];
    logic        nc [4];

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ctr_csr_bank #(.CNT_WIDTH(64)) dut (
        .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .csr_addr(csr_addr),
        .csr_re(csr_re), .csr_we(csr_we), .csr_wdata(csr_wdata), .priv(priv),
        .user_cnt_en(user_cnt_en), .csr_rdata(rd[0]), .csr_illegal(il[0]),
        .small_cnt(sm[0]), .no_cnt(nc[0]));
    ctr_csr_bank #(.CNT_WIDTH(40)) dut_w40 (
        .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .csr_addr(csr_addr),
        .csr_re(csr_re), .csr_we(csr_we), .csr_wdata(csr_wdata), .priv(priv),
        .user_cnt_en(user_cnt_en), .csr_rdata(rd[1]), .csr_illegal(il[1]),
        .small_cnt(sm[1]), .no_cnt(nc[1]));
    ctr_csr_bank #(.CNT_WIDTH(20)) dut_w20 (
        .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .csr_addr(csr_addr),
        .csr_re(csr_re), .csr_we(csr_we), .csr_wdata(csr_wdata), .priv(priv),
        .user_cnt_en(user_cnt_en), .csr_rdata(rd[2]), .csr_illegal(il[2]),
        .small_cnt(sm[2]), .no_cnt(nc[2]));
    ctr_csr_bank #(.CNT_WIDTH(0)) dut_w0 (
        .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .csr_addr(csr_addr),
        .csr_re(csr_re), .csr_we(csr_we), .csr_wdata(csr_wdata), .priv(priv),
        .user_cnt_en(user_cnt_en), .csr_rdata(rd[3]), .csr_illegal(il[3]),
        .small_cnt(sm[3]), .no_cnt(nc[3]));

    typedef struct {
        logic [31:0] e [4];
        logic        ill;
        string       req;
    } item_t;

    item_t sb_q [$];

    // Driver: drive one access after the falling edge, queue its expectation
    task automatic access(input logic [11:0] a, input logic re, input logic we,
                          input logic [31:0] wd, input logic [1:0] pv, input logic ret,
                          input logic chk,
                          input logic [31:0] e0, input logic [31:0] e1,
                          input logic [31:0] e2, input logic [31:0] e3,
                          input logic eill, input string req);
        item_t it;
        @(negedge clk);
        csr_addr  = a;
        csr_re    = re;
        csr_we    = we;
        csr_wdata = wd;
        priv      = pv;
        retire_i  = ret;
        if (chk) begin
            it.e[0] = e0; it.e[1] = e1; it.e[2] = e2; it.e[3] = e3;
            it.ill  = eill;
            it.req  = req;
            sb_q.push_back(it);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            access(12'h000, 0, 0, 0, PM, 0, 0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++)
            access(12'h000, 0, 0, 0, PM, 1, 0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] wd);
        access(a, 0, 1, wd, PM, 0, 0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic rdm(input logic [11:0] a, input logic [1:0] pv,
                       input logic [31:0] e0, input logic [31:0] e1,
                       input logic [31:0] e2, input logic [31:0] e3,
                       input logic eill, input string req);
        access(a, 1, 0, 0, pv, 0, 1, e0, e1, e2, e3, eill, req);
    endtask

    // Monitor: compare queued expectations shortly after the falling edge
    always @(negedge clk) begin
        item_t it;
        #1;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            for (int u = 0; u < 4; u++) begin
                tests++;
                if (rd[u] !== it.e[u] || il[u] !== it.ill) begin
                    fails++;
                    $display("FAIL %s unit%0d rdata=%h ill=%b expected rdata=%h ill=%b",
                             it.req, u, rd[u], il[u], it.e[u], it.ill);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [1:0] exp_flags [4];
        exp_flags[0] = 2'b00; exp_flags[1] = 2'b10;
        exp_flags[2] = 2'b10; exp_flags[3] = 2'b01;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 status flags
        for (int u = 0; u < 4; u++) begin
            tests++;
            if ({sm[u], nc[u]} !== exp_flags[u]) begin
                fails++;
                $display("FAIL R8 unit%0d flags=%b%b expected %b",
                         u, sm[u], nc[u], exp_flags[u]);
            end
        end

        // R1 reset values
        rdm(12'hB02, PM, 0, 0, 0, 0, 0, "R1 retire low");
        rdm(12'hB82, PM, 0, 0, 0, 0, 0, "R1 retire high");
        rdm(12'hB80, PM, 0, 0, 0, 0, 0, "R1 cycle high");

        // R12 quiet and non-counter address
        access(12'hB02, 0, 0, 0, PM, 0, 1, 0, 0, 0, 0, 0, "R12 no strobe");
        rdm(12'h300, PM, 0, 0, 0, 0, 0, "R12 other address");
        rdm(12'hB01, PU, 0, 0, 0, 0, 0, "R12 gap address");

        // R3 retire counting
        pulse(3);
        rdm(12'hB02, PM, 3, 3, 3, 0, 0, "R3 R7 three retires");

        // R4 write beats a same-cycle retire; write strobe itself is quiet
        access(12'hB02, 0, 1, 32'h1234_5678, PM, 1, 1, 0, 0, 0, 0, 0, "R12 write cycle");
        rdm(12'hB02, PM, 32'h1234_5678, 32'h1234_5678, 32'h0004_5678, 0, 0,
            "R4 R6 write priority");

        // R5 R6 masks on written values
        wr(12'hB02, 32'hFFFF_FFFF);
        wr(12'hB82, 32'hFFFF_FFFF);
        rdm(12'hB82, PM, 32'hFFFF_FFFF, 32'h0000_00FF, 0, 0, 0, "R5 R6 R7 high mask");
        rdm(12'hB02, PM, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h000F_FFFF, 0, 0, "R6 low mask");
        pulse(1);
        rdm(12'hB82, PM, 0, 0, 0, 0, 0, "R3 full wrap high");
        rdm(12'hB02, PM, 0, 0, 0, 0, 0, "R3 full wrap low");

        // R3 carry into high word
        wr(12'hB82, 32'h0000_0007);
        wr(12'hB02, 32'hFFFF_FFFF);
        pulse(1);
        rdm(12'hB82, PM, 8, 8, 0, 0, 0, "R3 carry high");
        rdm(12'hB02, PM, 0, 0, 0, 0, 0, "R3 carry low");

        // R9 user reads
        wr(12'hB02, 32'd2);
        user_cnt_en = 2'b10;
        rdm(12'hC02, PU, 2, 2, 2, 0, 0, "R9 enabled retire low");
        rdm(12'hC82, PU, 8, 8, 0, 0, 0, "R9 enabled retire high");
        rdm(12'hC00, PU, 0, 0, 0, 0, 1, "R9 disabled cycle");

        // R10 writes to user aliases
        access(12'hC02, 0, 1, 32'h55, PU, 0, 1, 0, 0, 0, 0, 1, "R10 user-level write");
        access(12'hC02, 0, 1, 32'h66, PM, 0, 1, 0, 0, 0, 0, 1, "R10 machine write to alias");
        rdm(12'hB02, PM, 2, 2, 2, 0, 0, "R10 unchanged");

        // R11 machine aliases from low privilege
        rdm(12'hB02, PU, 0, 0, 0, 0, 1, "R11 user read of machine word");
        access(12'hB02, 0, 1, 32'h99, PU, 0, 1, 0, 0, 0, 0, 1, "R11 user write of machine word");
        rdm(12'hB02, PM, 2, 2, 2, 0, 0, "R11 unchanged");
        user_cnt_en = 2'b00;
        rdm(12'hC02, PM, 2, 2, 2, 0, 0, "R11 machine ignores enables");

        // R2 cycle counting
        wr(12'hB00, 32'd100);
        idle(3);
        rdm(12'hB00, PM, 103, 103, 103, 0, 0, "R2 cycle count");
        user_cnt_en = 2'b01;
        rdm(12'hC00, PU, 104, 104, 104, 0, 0, "R2 R9 user cycle read");

        // R2 carry; R6 high write must not stall the small counter
        wr(12'hB00, 32'hFFFF_FFFE);
        wr(12'hB80, 32'h0000_0003);
        idle(2);
        rdm(12'hB80, PM, 4, 4, 0, 0, 0, "R2 R6 cycle carry high");
        rdm(12'hB00, PM, 1, 1, 2, 0, 0, "R2 R6 cycle low after carry");

        idle(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule